// File: doc/BRIEF.md
# Flag-Driven Accumulator Operate Unit

This block turns an accumulator value into its successor, steered by a small field of operator flags. Each flag bit selects one micro-operation. Any number of flags may be set at once. The selected operations form a chain, and each one works on the output of the one before it. The whole chain settles within one execute cycle.

The unit has a combinational next-value output and an accumulator register. The register captures that next value only on cycles where the enable input is high. A separate output goes high whenever the flag field is all zeros. In that case the operation is a no-operation and the value passes through unchanged.

Top module: `acc_operate_unit`

## Requirements
- R1: Flag bit 0 alone forces the next value to zero.
- R2: Flag bit 1 alone gives the bitwise inverse of the current value.
- R3: Flag bit 2 alone adds one, and 0xFF wraps to 0x00 with no carry reported.
- R4: Flag bit 3 alone rotates left by one place, so the old bit 7 lands in bit 0.
- R5: Flag bit 4 alone rotates right by one place, so the old bit 0 lands in bit 7.
- R6: With several flags set, the operations run in a fixed order: bit 0 first, then bit 1, bit 2, bit 3 and bit 4. Each operation takes the result of the previous one, so flags 0x03 always yield 0xFF.
- R7: An all-zero flag field passes the value through unchanged and drives `is_nop` high; any nonzero field drives `is_nop` low.
- R8: On a clock edge with `op_en` high, `acc_q` takes `acc_next`. With `op_en` low, `acc_q` keeps its value whatever the other inputs do.
- R9: While `rst_n` is low, `acc_q` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Loads the accumulator register with the result |
| acc_cur | input | 8 | Accumulator value to operate on |
| op_flags | input | 5 | Operator flag field |
| acc_next | output | 8 | Combinational result of the flag chain |
| acc_q | output | 8 | Registered accumulator |
| is_nop | output | 1 | High when the flag field is all zeros |

## Verification
The bench builds the block with its default widths: an 8-bit data path and a 5-bit flag field. At these widths the bit-7/bit-0 wrap of both rotates is visible, and the 0xFF-to-0x00 roll-over of the increment can be hit directly. Every pairing of flags that shows the ordering can also be tried.

Each scenario drives the flags and checks both the combinational result and the register load or hold against a reference model built into the bench. One scenario sweeps all 32 flag codes over several accumulator patterns.

// File: rtl/acc_ops_pkg.sv
package acc_ops_pkg;
   // Flag positions; the position is also the place of the step in the chain.
   localparam int OP_CLR = 0;
   localparam int OP_INV = 1;
   localparam int OP_INC = 2;
   localparam int OP_ROL = 3;
   localparam int OP_ROR = 4;
   localparam int OP_COUNT = 5;
endpackage

// File: rtl/acc_op_stage.sv
module acc_op_stage #(
   parameter int DATA_W = 8,
   parameter int KIND   = 0
) (
   input  logic              sel,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   import acc_ops_pkg::*;

   logic [DATA_W-1:0] op_res;

   generate
      if (KIND == OP_CLR) begin : g_clr
         assign op_res = '0;
      end else if (KIND == OP_INV) begin : g_inv
         assign op_res = ~din;
      end else if (KIND == OP_INC) begin : g_inc
         assign op_res = din + DATA_W'(1);
      end else if (KIND == OP_ROL) begin : g_rol
         assign op_res = {din[DATA_W-2:0], din[DATA_W-1]};
      end else if (KIND == OP_ROR) begin : g_ror
         assign op_res = {din[0], din[DATA_W-1:1]};
      end else begin : g_bad
         initial $fatal(1, "acc_op_stage: unknown KIND %0d", KIND);
         assign op_res = din;
      end
   endgenerate

   assign dout = sel ? op_res : din;
endmodule

// File: rtl/acc_op_chain.sv
module acc_op_chain #(
   parameter int DATA_W = 8,
   parameter int FLAG_W = 5
) (
   input  logic [DATA_W-1:0] din,
   input  logic [FLAG_W-1:0] flags,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] link [FLAG_W+1];

   assign link[0] = din;

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_step
         acc_op_stage #(
            .DATA_W (DATA_W),
            .KIND   (i)
         ) u_stage (
            .sel  (flags[i]),
            .din  (link[i]),
            .dout (link[i+1])
         );
      end
   endgenerate

   assign dout = link[FLAG_W];
endmodule

// File: rtl/acc_operate_unit.sv
module acc_operate_unit #(
   parameter int DATA_W = 8,
   parameter int FLAG_W = acc_ops_pkg::OP_COUNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_en,
   input  logic [DATA_W-1:0] acc_cur,
   input  logic [FLAG_W-1:0] op_flags,
   output logic [DATA_W-1:0] acc_next,
   output logic [DATA_W-1:0] acc_q,
   output logic              is_nop
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   initial begin
      if (DATA_W < 2) $fatal(1, "acc_operate_unit: DATA_W must be at least 2");
      if (FLAG_W != acc_ops_pkg::OP_COUNT)
         $fatal(1, "acc_operate_unit: FLAG_W must equal the operation count");
   end

   acc_op_chain #(
      .DATA_W (DATA_W),
      .FLAG_W (FLAG_W)
   ) u_chain (
      .din   (acc_cur),
      .flags (op_flags),
      .dout  (acc_next)
   );

   assign is_nop = ~|op_flags;

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (op_en) acc_q <= acc_next;
   end

   // R1
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_flags == FLAG_W'(1)) |-> (acc_next == '0));
   // R2
   invert_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_flags == FLAG_W'(2)) |-> ((acc_next ^ acc_cur) == ALL_ONES));
   // R3
   inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_flags == FLAG_W'(4) && acc_cur == ALL_ONES) |-> (acc_next == '0));
   // R4
   rol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_flags == FLAG_W'(8)) |-> (acc_next[0] == acc_cur[DATA_W-1]));
   // R5
   ror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_flags == FLAG_W'(16)) |-> (acc_next[DATA_W-1] == acc_cur[0]));
   // R6
   clr_then_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_flags == FLAG_W'(3)) |-> (acc_next == ALL_ONES));
   // R7
   nop_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_nop |-> (acc_next == acc_cur));
   // R8
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_en |=> (acc_q == $past(acc_next)));
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> $stable(acc_q));
endmodule

// File: tb/acc_operate_unit_bench.sv
module acc_operate_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_en = 1'b0;
   logic [7:0] acc_cur = 8'h00;
   logic [4:0] op_flags = 5'h00;
   logic [7:0] acc_next, acc_q;
   logic       is_nop;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   acc_operate_unit u_acc_operate_unit (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .acc_cur(acc_cur),
      .op_flags(op_flags), .acc_next(acc_next), .acc_q(acc_q), .is_nop(is_nop)
   );

   function automatic logic [7:0] model(input logic [7:0] a, input logic [4:0] f);
      logic [7:0] v = a;
      if (f[0]) v = 8'h00;
      if (f[1]) v = ~v;
      if (f[2]) v = v + 8'h01;
      if (f[3]) v = {v[6:0], v[7]};
      if (f[4]) v = {v[0], v[7:1]};
      return v;
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // apply at negedge, inspect comb outputs
   task automatic apply(input string req, input logic [7:0] a, input logic [4:0] f);
      @(negedge clk);
      acc_cur = a; op_flags = f; op_en = 1'b0;
      #2;
      check(req, acc_next, model(a, f));
      check({req, " nop"}, {7'd0, is_nop}, {7'd0, f == 5'd0});
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9", acc_q, 8'h00);
   endtask

   task automatic t_single();
      apply("R1", 8'hA5, 5'h01);
      apply("R2", 8'h3C, 5'h02);
      check("R2", acc_next, 8'hC3);
      apply("R3", 8'h41, 5'h04);
      apply("R3", 8'hFF, 5'h04);
      check("R3", acc_next, 8'h00);
      apply("R4", 8'h81, 5'h08);
      check("R4", acc_next, 8'h03);
      apply("R5", 8'h01, 5'h10);
      check("R5", acc_next, 8'h80);
   endtask

   task automatic t_order();
      apply("R6", 8'h12, 5'h03);
      check("R6", acc_next, 8'hFF);
      apply("R6", 8'h0F, 5'h06);
      check("R6", acc_next, 8'hF1);
      apply("R6", 8'h7F, 5'h0C);
      check("R6", acc_next, 8'h01);
      apply("R6", 8'h96, 5'h18);
      check("R6", acc_next, 8'h96);
      apply("R6", 8'h5A, 5'h1F);
      check("R6", acc_next, 8'h00);
   endtask

   task automatic t_nop();
      apply("R7", 8'hC7, 5'h00);
      check("R7", acc_next, 8'hC7);
      check("R7", {7'd0, is_nop}, 8'h01);
      apply("R7", 8'hC7, 5'h10);
      check("R7", {7'd0, is_nop}, 8'h00);
   endtask

   task automatic t_sweep();
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h80, 8'h6B};
      for (int p = 0; p < 4; p++)
         for (int f = 0; f < 32; f++)
            apply("R6 sweep", pats[p], 5'(f));
   endtask

   task automatic t_register();
      logic [7:0] held;
      @(negedge clk);
      acc_cur = 8'h33; op_flags = 5'h04; op_en = 1'b1;
      @(negedge clk);
      check("R8 load", acc_q, 8'h34);
      held = acc_q;
      acc_cur = 8'h99; op_flags = 5'h02; op_en = 1'b0;
      @(negedge clk);
      acc_cur = 8'h01; op_flags = 5'h01;
      @(negedge clk);
      check("R8 hold", acc_q, held);
      acc_cur = 8'h81; op_flags = 5'h08; op_en = 1'b1;
      @(negedge clk);
      check("R8 load", acc_q, 8'h03);
      op_en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R9", acc_q, 8'h00);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_single();
      t_order();
      t_nop();
      t_sweep();
      t_register();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule